// File: doc/BRIEF.md
# Masked Packed Float-to-Unsigned Converter

This vector execution unit turns a packed group of IEEE-754 single-precision values into 32-bit unsigned integers, one lane per 32-bit slice. The active vector length is chosen per operation: 128, 256 or 512 bits, which is 4, 8 or 16 lanes. A per-lane write mask decides which lanes receive a converted value. Lanes that the mask turns off either keep the old destination contents or are forced to zero. Lanes above the active length are always cleared.

The rounding mode normally comes from a global control field. A per-operation override replaces it only for full-width register-sourced operations. A memory-style source can also be broadcast, so that every lane converts the lowest 32-bit element. Inputs that no unsigned 32-bit value can hold saturate to all ones and raise the invalid flag. Inexact results raise the precision flag. Both flags are reported per operation and also gathered into sticky copies. A bad reserved specifier field aborts the operation with an undefined-opcode error.

Top module: `fcvt_u32_vec`

## Requirements
- R1: Lane j converts source bits [32j+31:32j]. Exactly representable values in range (for example 1.0, 123456.0, 0x4F7FFFFF, -0.0) yield their integer value with no flag set.
- R2: `rc_glob`/`rc_ovr` use 00 for nearest-even, 01 for toward minus infinity, 10 for toward plus infinity and 11 for toward zero, and each mode rounds 2.5, 3.5 and the smallest denormal accordingly.
- R3: With `mask_en` = 1, an active lane whose `lane_mask` bit is 0 returns its `old_dst` slice when `zero_mode` = 0, and returns 0 when `zero_mode` = 1.
- R4: With `mask_en` = 0, every active lane is converted whatever `lane_mask` holds.
- R5: `vlen_sel` 0 selects 4 lanes, 1 selects 8 lanes, and 2 or 3 selects 16 lanes. Result bits of the lanes above the selected count are 0.
- R6: With `src_is_mem` = 1 and `bcast` = 1, every active lane converts `src_vec[31:0]`.
- R7: `rc_ovr` is used only when `vlen_sel` selects 16 lanes, `src_is_mem` = 0 and `bcast` = 1. Every other operation uses `rc_glob`, and a register source never broadcasts.
- R8: NaN, either infinity, and positive values that round to 2^32 or more yield 0xFFFFFFFF and set the invalid flag.
- R9: A negative input whose rounded magnitude is nonzero is invalid (0xFFFFFFFF). One that rounds to zero yields 0 with no invalid flag.
- R10: `op_prec` is set by an inexact valid conversion. `op_inv` and `op_prec` are the OR over active lanes that are converted only, so masked-off and inactive lanes add nothing.
- R11: `sticky_inv` and `sticky_prec` accumulate the per-operation flags of every accepted operation and are cleared only by reset.
- R12: When `rsvd_spec` is not 4'b1111, `ud_err` is 1, the result equals `old_dst` in full, the per-operation flags are 0 and the sticky flags are unchanged.
- R13: The result, flags and `out_valid` appear one clock after `in_valid`, `out_valid` is high for exactly that cycle, and reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| vlen_sel | input | 2 | Vector length select (0: 4 lanes, 1: 8, 2/3: 16) |
| src_is_mem | input | 1 | Source is memory-style |
| bcast | input | 1 | Broadcast / rounding-override bit |
| rc_ovr | input | 2 | Per-operation rounding mode |
| rc_glob | input | 2 | Global rounding mode |
| mask_en | input | 1 | Write masking enabled |
| zero_mode | input | 1 | 1: zero masked lanes, 0: merge |
| lane_mask | input | LANES | Per-lane write mask |
| rsvd_spec | input | 4 | Reserved specifier field, must be 4'b1111 |
| src_vec | input | 32*LANES | Packed single-precision source |
| old_dst | input | 32*LANES | Previous destination contents |
| out_valid | output | 1 | Result valid |
| result | output | 32*LANES | Converted destination |
| op_inv | output | 1 | Invalid flag of the last operation |
| op_prec | output | 1 | Precision flag of the last operation |
| sticky_inv | output | 1 | Accumulated invalid flag |
| sticky_prec | output | 1 | Accumulated precision flag |
| ud_err | output | 1 | Undefined-opcode error of the last operation |

## Verification
The bench builds the unit with its default of 16 lanes, so all three vector lengths can be selected at run time. This covers the clearing of the upper lanes for 4 and 8 lanes, and it makes the full-width-only rounding override reachable next to shorter lengths that must ignore it. A bench-side rounding model based on quotient and remainder supplies the expected value for each lane. It is exercised with ties, denormals, negative fractions, out-of-range values, NaN and infinity placed in active, masked-off and inactive lanes.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

    localparam int LANE_W = 32;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    typedef struct packed {
        logic [LANE_W-1:0] val;
        logic              inv;
        logic              inexact;
    } lane_res_t;

endpackage

// File: rtl/fcvt_lane_conv.sv
module fcvt_lane_conv
    import fcvt_pkg::*;
(
    input  logic [LANE_W-1:0] fp_in,
    input  rmode_e            rm,
    output lane_res_t         res
);

    localparam logic [7:0] BIAS_INT = 8'd150;  // exponent at which the significand LSB weighs 1
    localparam logic [7:0] MAX_LSH  = 8'd8;    // 24-bit significand shifted 8 fills 32 bits
    localparam logic [7:0] MAX_RSH  = 8'd25;

    logic        sgn;
    logic [7:0]  ex;
    logic [7:0]  eff;
    logic [23:0] sig;
    logic [7:0]  shamt;
    logic [49:0] wide;
    logic [31:0] ip;
    logic        rnd;
    logic        stk;
    logic        big;
    logic        inc;
    logic [32:0] mag;

    always_comb begin
        sgn   = fp_in[31];
        ex    = fp_in[30:23];
        sig   = {(ex != 8'd0), fp_in[22:0]};
        eff   = (ex == 8'd0) ? 8'd1 : ex;
        ip    = '0;
        rnd   = 1'b0;
        stk   = 1'b0;
        big   = 1'b0;
        wide  = '0;
        shamt = '0;

        if (eff >= BIAS_INT) begin
            shamt = eff - BIAS_INT;
            if (shamt > MAX_LSH) begin
                big = 1'b1;
            end else begin
                ip = {8'd0, sig} << shamt;
            end
        end else begin
            shamt = BIAS_INT - eff;
            if (shamt > MAX_RSH) begin
                stk = |sig;
            end else begin
                wide = {sig, 26'd0} >> shamt;
                ip   = {8'd0, wide[49:26]};
                rnd  = wide[25];
                stk  = |wide[24:0];
            end
        end

        case (rm)
            RM_NEAR: inc = rnd & (stk | ip[0]);
            RM_DOWN: inc = sgn & (rnd | stk);
            RM_UP:   inc = ~sgn & (rnd | stk);
            default: inc = 1'b0;
        endcase

        mag = {1'b0, ip} + {32'd0, inc};

        if ((ex == 8'hFF) || big || (!sgn && mag[32]) || (sgn && (mag != 33'd0))) begin
            res.val     = '1;
            res.inv     = 1'b1;
            res.inexact = 1'b0;
        end else begin
            res.val     = mag[31:0];
            res.inv     = 1'b0;
            res.inexact = rnd | stk;
        end
    end

endmodule

// File: rtl/fcvt_mode_sel.sv
module fcvt_mode_sel
    import fcvt_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic [1:0]       vlen_sel,
    input  logic             src_is_mem,
    input  logic             bcast,
    input  logic [1:0]       rc_ovr,
    input  logic [1:0]       rc_glob,
    output rmode_e           rm,
    output logic             use_bcast,
    output logic [LANES-1:0] lane_act
);

    localparam int CNT_W = $clog2(LANES + 1) + 2;

    logic [CNT_W-1:0] lane_cnt;
    logic             full_len;

    always_comb begin
        case (vlen_sel)
            2'd0:    lane_cnt = CNT_W'(4);
            2'd1:    lane_cnt = CNT_W'(8);
            default: lane_cnt = CNT_W'(16);
        endcase
        full_len  = vlen_sel[1];
        rm        = rmode_e'((full_len && !src_is_mem && bcast) ? rc_ovr : rc_glob);
        use_bcast = src_is_mem & bcast;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_act
        assign lane_act[j] = (CNT_W'(j) < lane_cnt);
    end

endmodule

// File: rtl/fcvt_u32_vec.sv
module fcvt_u32_vec
    import fcvt_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [1:0]              vlen_sel,
    input  logic                    src_is_mem,
    input  logic                    bcast,
    input  logic [1:0]              rc_ovr,
    input  logic [1:0]              rc_glob,
    input  logic                    mask_en,
    input  logic                    zero_mode,
    input  logic [LANES-1:0]        lane_mask,
    input  logic [3:0]              rsvd_spec,
    input  logic [LANES*LANE_W-1:0] src_vec,
    input  logic [LANES*LANE_W-1:0] old_dst,
    output logic                    out_valid,
    output logic [LANES*LANE_W-1:0] result,
    output logic                    op_inv,
    output logic                    op_prec,
    output logic                    sticky_inv,
    output logic                    sticky_prec,
    output logic                    ud_err
);

    localparam int         VW        = LANES * LANE_W;
    localparam logic [3:0] RSVD_GOOD = 4'b1111;

    typedef struct packed {
        logic          vld;
        logic [VW-1:0] res;
        logic          oi;
        logic          op;
        logic          si;
        logic          sp;
        logic          ud;
    } state_t;

    state_t st_d, st_q;

    rmode_e           rm;
    logic             use_bcast;
    logic [LANES-1:0] lane_act;
    logic [LANE_W-1:0] lane_in [LANES];
    lane_res_t        conv    [LANES];

    fcvt_mode_sel #(.LANES(LANES)) u_mode (
        .vlen_sel   (vlen_sel),
        .src_is_mem (src_is_mem),
        .bcast      (bcast),
        .rc_ovr     (rc_ovr),
        .rc_glob    (rc_glob),
        .rm         (rm),
        .use_bcast  (use_bcast),
        .lane_act   (lane_act)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign lane_in[j] = use_bcast ? src_vec[LANE_W-1:0] : src_vec[j*LANE_W +: LANE_W];

        fcvt_lane_conv u_conv (
            .fp_in (lane_in[j]),
            .rm    (rm),
            .res   (conv[j])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            if (rsvd_spec != RSVD_GOOD) begin
                st_d.res = old_dst;
                st_d.oi  = 1'b0;
                st_d.op  = 1'b0;
                st_d.ud  = 1'b1;
            end else begin
                st_d.oi = 1'b0;
                st_d.op = 1'b0;
                st_d.ud = 1'b0;
                for (int j = 0; j < LANES; j++) begin
                    if (!lane_act[j]) begin
                        st_d.res[j*LANE_W +: LANE_W] = '0;
                    end else if (!mask_en || lane_mask[j]) begin
                        st_d.res[j*LANE_W +: LANE_W] = conv[j].val;
                        st_d.oi = st_d.oi | conv[j].inv;
                        st_d.op = st_d.op | conv[j].inexact;
                    end else if (zero_mode) begin
                        st_d.res[j*LANE_W +: LANE_W] = '0;
                    end else begin
                        st_d.res[j*LANE_W +: LANE_W] = old_dst[j*LANE_W +: LANE_W];
                    end
                end
                st_d.si = st_q.si | st_d.oi;
                st_d.sp = st_q.sp | st_d.op;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.vld;
    assign result      = st_q.res;
    assign op_inv      = st_q.oi;
    assign op_prec     = st_q.op;
    assign sticky_inv  = st_q.si;
    assign sticky_prec = st_q.sp;
    assign ud_err      = st_q.ud;

endmodule

// File: rtl/fcvt_u32_vec_chk.sv
module fcvt_u32_vec_chk #(
    parameter int LANES = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [1:0]          vlen_sel,
    input logic                mask_en,
    input logic                zero_mode,
    input logic [LANES-1:0]    lane_mask,
    input logic [3:0]          rsvd_spec,
    input logic [LANES*32-1:0] src_vec,
    input logic [LANES*32-1:0] old_dst,
    input logic                out_valid,
    input logic [LANES*32-1:0] result,
    input logic                op_inv,
    input logic                op_prec,
    input logic                sticky_inv,
    input logic                sticky_prec,
    input logic                ud_err
);

    a_r13_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r12_keep_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rsvd_spec != 4'b1111) |=> (ud_err && result == $past(old_dst)));

    a_r12_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ud_err |-> (!op_inv && !op_prec));

    a_r5_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rsvd_spec == 4'b1111 && vlen_sel == 2'd0) |=> (result[LANES*32-1:128] == '0));

    a_r3_zeroing: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rsvd_spec == 4'b1111 && mask_en && zero_mode && !lane_mask[0])
        |=> (result[31:0] == 32'd0));

    a_r3_merging: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rsvd_spec == 4'b1111 && mask_en && !zero_mode && !lane_mask[0])
        |=> (result[31:0] == $past(old_dst[31:0])));

    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rsvd_spec == 4'b1111 && !mask_en && (&src_vec[30:23]))
        |=> (result[31:0] == 32'hFFFF_FFFF && op_inv));

    a_r11_sticky_inv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_inv |=> sticky_inv);

    a_r11_sticky_prec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_prec |=> sticky_prec);

endmodule

bind fcvt_u32_vec fcvt_u32_vec_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/test_fcvt_u32_vec.sv
`timescale 1ns/1ps
module test_fcvt_u32_vec;

    localparam int L  = 16;
    localparam int VW = L * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    vlen_sel = '0;
    logic          src_is_mem = 1'b0;
    logic          bcast = 1'b0;
    logic [1:0]    rc_ovr = '0;
    logic [1:0]    rc_glob = '0;
    logic          mask_en = 1'b0;
    logic          zero_mode = 1'b0;
    logic [L-1:0]  lane_mask = '0;
    logic [3:0]    rsvd_spec = 4'hF;
    logic [VW-1:0] src_vec = '0;
    logic [VW-1:0] old_dst = '0;
    logic          out_valid;
    logic [VW-1:0] result;
    logic          op_inv, op_prec, sticky_inv, sticky_prec, ud_err;

    int checks = 0;
    int errors = 0;
    bit m_si = 1'b0;
    bit m_sp = 1'b0;

    typedef struct {
        logic [VW-1:0] res;
        bit oi, op, si, sp, ud;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    fcvt_u32_vec #(.LANES(L)) i_fcvt_u32_vec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vlen_sel(vlen_sel),
        .src_is_mem(src_is_mem), .bcast(bcast), .rc_ovr(rc_ovr), .rc_glob(rc_glob),
        .mask_en(mask_en), .zero_mode(zero_mode), .lane_mask(lane_mask),
        .rsvd_spec(rsvd_spec), .src_vec(src_vec), .old_dst(old_dst),
        .out_valid(out_valid), .result(result), .op_inv(op_inv), .op_prec(op_prec),
        .sticky_inv(sticky_inv), .sticky_prec(sticky_prec), .ud_err(ud_err)
    );

    function automatic void ref_conv(input logic [31:0] f, input logic [1:0] rm,
                                     output logic [31:0] v, output bit inv, output bit px);
        bit s;
        int e, sh, n, cmp;
        longint sig, q, rem, half, mag;
        bit up;
        s = f[31];
        e = int'(f[30:23]);
        inv = 1'b0; px = 1'b0; v = '0; q = 0; rem = 0; cmp = 0;
        if (e == 255) begin inv = 1'b1; v = '1; return; end
        sig = (e != 0) ? ((longint'(1) << 23) | longint'(f[22:0])) : longint'(f[22:0]);
        sh  = ((e != 0) ? e : 1) - 150;
        if (sh >= 0) begin
            if (sh > 8) begin inv = 1'b1; v = '1; return; end
            q = sig << sh;
        end else begin
            n = -sh;
            if (n >= 40) begin
                q = 0; rem = sig; cmp = -1;
            end else begin
                q    = sig >> n;
                rem  = sig - (q << n);
                half = longint'(1) << (n - 1);
                cmp  = (rem > half) ? 1 : ((rem == half) ? 0 : -1);
            end
        end
        up = 1'b0;
        if (rem != 0) begin
            case (rm)
                2'd0:    up = (cmp > 0) || (cmp == 0 && q[0]);
                2'd1:    up = s;
                2'd2:    up = !s;
                default: up = 1'b0;
            endcase
        end
        mag = q + longint'(up);
        if ((s && mag != 0) || (!s && mag >= (longint'(1) << 32))) begin
            inv = 1'b1; v = '1; return;
        end
        v  = mag[31:0];
        px = (rem != 0);
    endfunction

    function automatic logic [VW-1:0] rep4(input logic [31:0] a, b, c, d);
        logic [VW-1:0] r;
        for (int j = 0; j < L; j += 4) r[j*32 +: 128] = {d, c, b, a};
        return r;
    endfunction

    function automatic logic [VW-1:0] seqw(input logic [31:0] base);
        logic [VW-1:0] r;
        for (int j = 0; j < L; j++) r[j*32 +: 32] = base + 32'(j);
        return r;
    endfunction

    task automatic send(input logic [1:0] vl, input bit mem, input bit bc,
                        input logic [1:0] ovr, input logic [1:0] glob,
                        input bit men, input bit zm, input logic [L-1:0] msk,
                        input logic [3:0] rsv, input logic [VW-1:0] src,
                        input logic [VW-1:0] old, input string tag);
        exp_t e;
        int kl;
        logic [1:0] rm;
        logic [31:0] v, lane_src;
        bit iv, px;
        @(negedge clk);
        vlen_sel = vl; src_is_mem = mem; bcast = bc; rc_ovr = ovr; rc_glob = glob;
        mask_en = men; zero_mode = zm; lane_mask = msk; rsvd_spec = rsv;
        src_vec = src; old_dst = old; in_valid = 1'b1;
        e.tag = tag; e.oi = 1'b0; e.op = 1'b0; e.res = '0;
        if (rsv != 4'hF) begin
            e.res = old; e.ud = 1'b1;
        end else begin
            e.ud = 1'b0;
            kl = (vl == 2'd0) ? 4 : ((vl == 2'd1) ? 8 : 16);
            rm = (vl[1] && !mem && bc) ? ovr : glob;
            for (int j = 0; j < kl; j++) begin
                if (!men || msk[j]) begin
                    lane_src = (mem && bc) ? src[31:0] : src[j*32 +: 32];
                    ref_conv(lane_src, rm, v, iv, px);
                    e.res[j*32 +: 32] = v;
                    e.oi |= iv; e.op |= px;
                end else if (!zm) begin
                    e.res[j*32 +: 32] = old[j*32 +: 32];
                end
            end
            m_si |= e.oi; m_sp |= e.op;
        end
        e.si = m_si; e.sp = m_sp;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic check_reset_state();
        @(negedge clk);
        checks++;
        if (out_valid || result != '0 || op_inv || op_prec || sticky_inv || sticky_prec || ud_err) begin
            errors++;
            $display("FAIL R13 reset state: vld=%0b inv=%0b prec=%0b si=%0b sp=%0b ud=%0b res_nonzero=%0b expected all 0",
                     out_valid, op_inv, op_prec, sticky_inv, sticky_prec, ud_err, (result != '0));
        end
    endtask

    task automatic do_reset();
        idle(3);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        m_si = 1'b0; m_sp = 1'b0;
        check_reset_state();
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R13 out_valid with no pending operation: actual 1 expected 0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (result !== e.res || op_inv !== e.oi || op_prec !== e.op ||
                    sticky_inv !== e.si || sticky_prec !== e.sp || ud_err !== e.ud) begin
                    errors++;
                    $display("FAIL %s actual res=%h inv=%0b prec=%0b si=%0b sp=%0b ud=%0b expected res=%h inv=%0b prec=%0b si=%0b sp=%0b ud=%0b",
                             e.tag, result, op_inv, op_prec, sticky_inv, sticky_prec, ud_err,
                             e.res, e.oi, e.op, e.si, e.sp, e.ud);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    localparam logic [31:0] F_ONE  = 32'h3F80_0000;
    localparam logic [31:0] F_BIG  = 32'h47F1_2000; // 123456.0
    localparam logic [31:0] F_TOP  = 32'h4F7F_FFFF; // 2^32-256
    localparam logic [31:0] F_NZ   = 32'h8000_0000;
    localparam logic [31:0] F_2P5  = 32'h4020_0000;
    localparam logic [31:0] F_3P5  = 32'h4060_0000;
    localparam logic [31:0] F_MH   = 32'hBF00_0000; // -0.5
    localparam logic [31:0] F_DEN  = 32'h0000_0001;
    localparam logic [31:0] F_NAN  = 32'h7FC0_0000;
    localparam logic [31:0] F_INF  = 32'h7F80_0000;
    localparam logic [31:0] F_2P32 = 32'h4F80_0000;
    localparam logic [31:0] F_M1   = 32'hBF80_0000;
    localparam logic [31:0] F_MP3  = 32'hBE99_999A; // -0.3
    localparam logic [31:0] F_TWO  = 32'h4000_0000;

    initial begin
        idle(3);
        rst_n = 1'b1;
        check_reset_state();

        // R1 exact conversions, lane order
        send(2'd2, 0, 0, 2'd0, 2'd0, 0, 0, '0, 4'hF, rep4(F_ONE, F_BIG, F_TOP, F_NZ), '0, "R1 exact 16 lanes");
        send(2'd2, 0, 0, 2'd0, 2'd0, 0, 0, '0, 4'hF, rep4(F_NZ, F_TOP, F_ONE, F_BIG), '1, "R1 exact permuted");
        // R2 rounding modes, back to back (R13)
        for (int m = 0; m < 4; m++)
            send(2'd2, 0, 0, 2'd0, 2'(m), 0, 0, '0, 4'hF, rep4(F_2P5, F_3P5, F_MH, F_DEN), '0, "R2 rounding mode");
        idle(2);
        do_reset();
        // R5 vector lengths
        send(2'd0, 0, 0, 2'd0, 2'd0, 0, 0, '0, 4'hF, rep4(F_ONE, F_TWO, F_3P5, F_BIG), seqw(32'hA000_0000), "R5 four lanes upper clear");
        send(2'd1, 0, 0, 2'd0, 2'd0, 0, 0, '0, 4'hF, rep4(F_ONE, F_TWO, F_3P5, F_BIG), seqw(32'hA000_0000), "R5 eight lanes upper clear");
        send(2'd3, 0, 0, 2'd0, 2'd0, 0, 0, '0, 4'hF, rep4(F_ONE, F_TWO, F_3P5, F_BIG), seqw(32'hA000_0000), "R5 code 3 full width");
        // R3 / R4 masking
        send(2'd1, 0, 0, 2'd0, 2'd0, 1, 0, 16'h00A5, 4'hF, rep4(F_2P5, F_ONE, F_BIG, F_TWO), seqw(32'h1234_0000), "R3 merge policy");
        send(2'd1, 0, 0, 2'd0, 2'd0, 1, 1, 16'h00A5, 4'hF, rep4(F_2P5, F_ONE, F_BIG, F_TWO), seqw(32'h1234_0000), "R3 zero policy");
        send(2'd2, 0, 0, 2'd0, 2'd0, 0, 1, 16'h0000, 4'hF, rep4(F_2P5, F_ONE, F_BIG, F_TWO), seqw(32'h1234_0000), "R4 mask disabled");
        // R6 broadcast from memory
        send(2'd1, 1, 1, 2'd2, 2'd0, 0, 0, '0, 4'hF, {rep4(F_ONE, F_ONE, F_ONE, F_ONE)} | VW'(F_3P5), '0, "R6 broadcast 8 lanes");
        send(2'd2, 1, 0, 2'd0, 2'd0, 0, 0, '0, 4'hF, rep4(F_3P5, F_ONE, F_TWO, F_BIG), '0, "R6 memory no broadcast");
        // R7 override rule
        send(2'd2, 0, 1, 2'd2, 2'd0, 0, 0, '0, 4'hF, rep4(F_2P5, F_3P5, F_DEN, F_ONE), '0, "R7 override full-width register");
        send(2'd2, 1, 1, 2'd2, 2'd0, 0, 0, '0, 4'hF, rep4(F_2P5, F_3P5, F_DEN, F_ONE), '0, "R7 memory keeps global mode");
        send(2'd1, 0, 1, 2'd2, 2'd3, 0, 0, '0, 4'hF, rep4(F_2P5, F_3P5, F_DEN, F_ONE), '0, "R7 short length keeps global mode");
        idle(2);
        do_reset();
        // R10 flags only from active unmasked lanes
        send(2'd0, 0, 0, 2'd0, 2'd0, 1, 1, 16'h0005, 4'hF,
             {{12{F_NAN}}, F_NAN, F_TWO, F_2P5, F_ONE}, '0, "R10 masked and inactive lanes add no flags");
        send(2'd0, 0, 0, 2'd0, 2'd0, 1, 0, 16'h0002, 4'hF,
             {{12{F_NAN}}, F_NAN, F_TWO, F_2P5, F_ONE}, seqw(32'h7700_0000), "R10 precision from unmasked lane");
        idle(2);
        do_reset();
        // R8 / R9 invalid and negatives
        send(2'd2, 0, 0, 2'd0, 2'd0, 0, 0, '0, 4'hF, rep4(F_NAN, F_INF, F_2P32, F_TOP), '0, "R8 unrepresentable saturate");
        send(2'd2, 0, 0, 2'd0, 2'd3, 0, 0, '0, 4'hF, rep4(F_MP3, F_MH, F_NZ, F_ONE), '0, "R9 negative rounds to zero");
        send(2'd2, 0, 0, 2'd0, 2'd1, 0, 0, '0, 4'hF, rep4(F_MP3, F_M1, F_NZ, F_ONE), '0, "R9 negative nonzero invalid");
        // R11 sticky persists over clean op
        send(2'd2, 0, 0, 2'd0, 2'd0, 0, 0, '0, 4'hF, rep4(F_ONE, F_TWO, F_BIG, F_TOP), '0, "R11 sticky after clean op");
        // R12 undefined-opcode
        send(2'd2, 0, 0, 2'd0, 2'd0, 0, 0, '0, 4'hE, rep4(F_NAN, F_2P5, F_ONE, F_ONE), seqw(32'h5500_0000), "R12 bad reserved field");
        send(2'd0, 0, 0, 2'd0, 2'd0, 1, 1, 16'h0000, 4'h7, rep4(F_NAN, F_2P5, F_ONE, F_ONE), seqw(32'h6600_0000), "R12 bad field ignores mask and length");
        send(2'd0, 0, 0, 2'd0, 2'd0, 0, 0, '0, 4'hF, rep4(F_ONE, F_TWO, F_ONE, F_TWO), '0, "R12 recovery clears error");
        idle(4);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R13 pending results: actual %0d expected 0", sb.size());
        end
        do_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule